// File: doc/BRIEF.md
# OTP Byte-Programming Sequencer

This block is a host-side controller that burns a short list of configuration bytes into the one-time-programmable store of a sensor. Each list entry holds a target OTP location and a data byte. The controller reaches the sensor only through a generic register read/write port with request and acknowledge. One start pulse makes it walk the whole list. It switches on the OTP clock once. For each entry it then arms the OTP block, loads the location and the data byte, fires the program bit, and polls that bit until the sensor clears it. Last, it reads a pass bit.

A byte that fails is re-driven from the data write, up to a fixed number of attempts. When the attempts run out, the controller stops and marks the device defective. Entries whose data byte is zero are skipped, because blank OTP already reads back as zero. An entry that names a location outside the OTP window ends the run with an address error, and no bus traffic is issued for it. A program bit that never clears ends the run with a timeout error. Busy, done and the result flags stay readable until the next start, together with the index of the entry that failed.

Top module: `otp_prog_seq`

## Requirements
- R1: A start pulse seen while idle raises busy in the next cycle and clears done and every result flag. The first bus transaction of the run is a write of 0x01 to register 0x42.
- R2: List entry k sits at bits [8k+7:8k] of entry_addr and entry_data. Entries are handled in rising index order from 0 to n_entries-1. A programmed entry issues, in this order: write 0x01 to 0x51, write the location to 0x52, write the data to 0x53, write 0x01 to 0x54, then reads of 0x54.
- R3: Reads of 0x54 repeat while bit 0 of the returned data is 1. The first read that returns bit 0 = 0 is followed by one read of 0x58.
- R4: Bit 0 = 1 from 0x58 passes the entry, and the sequencer moves on to the next entry. Bit 0 = 0 retries the entry starting again at the write to 0x53, without rewriting 0x51 or 0x52.
- R5: When the MAX_TRIES-th (default 10) read of 0x58 for one entry returns 0, the run ends with done=1, defective=1, pass=0 and fail_idx equal to that entry's index.
- R6: An entry whose data byte is 0x00 causes no bus transaction at all.
- R7: An entry whose location lies outside 0xDF..0xE8 ends the run with done=1, addr_err=1, pass=0 and fail_idx equal to its index. No bus transaction is issued for that entry.
- R8: If POLL_LIMIT (default 64) reads of 0x54 in a row return bit 0 = 1, the run ends after the last of those reads with done=1, timeout_err=1, and defective=0 and pass=0.
- R9: When every entry has either passed or been skipped, the run ends with done=1 and pass=1. Exactly one of pass, defective, timeout_err and addr_err is set whenever done is 1.
- R10: Once bus_req is raised, it stays high with bus_we, bus_addr and bus_wdata unchanged until a cycle in which bus_ack is sampled high.
- R11: While busy is low, bus_req is low. A start pulse while busy is high has no effect.
- R12: done, the result flags and fail_idx keep their values from the end of a run until the next start pulse. done is never high while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| n_entries | input | IDXW | Number of list entries to process |
| entry_addr | input | 8*MAX_ENTRIES | Packed OTP target locations, entry k at [8k+7:8k] |
| entry_data | input | 8*MAX_ENTRIES | Packed data bytes, entry k at [8k+7:8k] |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transaction complete |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| pass | output | 1 | All entries passed or were skipped |
| defective | output | 1 | Retry bound reached on an entry |
| timeout_err | output | 1 | Program bit never cleared |
| addr_err | output | 1 | Entry location out of the OTP window |
| fail_idx | output | IDXW | Index of the entry that ended the run |

## Verification
Most wrong internal states show up quickly on the bus. A wrong state or entry index puts a wrong register address or data byte on the very next request, so the bench compares the complete transaction log of each run against a sequence built from the requirements. A retry or poll counter that is off by one changes only the count of 0x53 writes or 0x54 reads. That becomes visible after the last attempt, as a longer or shorter log and a wrong result flag. A flag register that is not cleared or not held shows up one cycle after start, or while the block sits idle between runs.

// File: rtl/otp_seq_pkg.sv
`timescale 1ns/1ps
package otp_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CLKEN, S_PICK, S_CFG, S_ADDR, S_DATA, S_PROG, S_POLL, S_STAT
    } seq_state_t;

    localparam logic [7:0] REG_CLK  = 8'h42;
    localparam logic [7:0] REG_CFG  = 8'h51;
    localparam logic [7:0] REG_ADDR = 8'h52;
    localparam logic [7:0] REG_DATA = 8'h53;
    localparam logic [7:0] REG_CTRL = 8'h54;
    localparam logic [7:0] REG_STAT = 8'h58;
    localparam logic [7:0] OTP_LO   = 8'hDF;
    localparam logic [7:0] OTP_HI   = 8'hE8;

    typedef struct packed {
        logic done;
        logic pass;
        logic defective;
        logic timeout_err;
        logic addr_err;
    } seq_result_t;

    typedef struct packed {
        logic       req;
        logic       we;
        logic [7:0] addr;
        logic [7:0] wdata;
    } bus_cmd_t;

    function automatic logic in_otp_range(input logic [7:0] a);
        return (a >= OTP_LO) && (a <= OTP_HI);
    endfunction

endpackage

// File: rtl/otp_entry_sel.sv
`timescale 1ns/1ps
module otp_entry_sel #(
    parameter int MAX_ENTRIES = 4,
    parameter int IDXW        = 3
) (
    input  logic [IDXW-1:0]          n_entries,
    input  logic [IDXW-1:0]          idx,
    input  logic [8*MAX_ENTRIES-1:0] entry_addr,
    input  logic [8*MAX_ENTRIES-1:0] entry_data,
    output logic [7:0]               cur_addr,
    output logic [7:0]               cur_data,
    output logic                     past_end,
    output logic                     addr_ok,
    output logic                     is_zero
);
    import otp_seq_pkg::*;

    localparam int SLOTS = 1 << IDXW;

    logic [7:0] loc_tab [SLOTS];
    logic [7:0] dat_tab [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k < MAX_ENTRIES) begin : g_real
            assign loc_tab[k] = entry_addr[8*k +: 8];
            assign dat_tab[k] = entry_data[8*k +: 8];
        end else begin : g_pad
            assign loc_tab[k] = 8'h00;
            assign dat_tab[k] = 8'h00;
        end
    end

    assign cur_addr = loc_tab[idx];
    assign cur_data = dat_tab[idx];
    assign past_end = (idx >= n_entries) || (idx >= IDXW'(MAX_ENTRIES));
    assign addr_ok  = in_otp_range(cur_addr);
    assign is_zero  = (cur_data == 8'h00);
endmodule

// File: rtl/otp_bus_map.sv
`timescale 1ns/1ps
module otp_bus_map (
    input  otp_seq_pkg::seq_state_t state,
    input  logic [7:0]              cur_addr,
    input  logic [7:0]              cur_data,
    output otp_seq_pkg::bus_cmd_t   cmd
);
    import otp_seq_pkg::*;

    always_comb begin
        cmd = '0;
        unique case (state)
            S_CLKEN: cmd = '{req: 1'b1, we: 1'b1, addr: REG_CLK,  wdata: 8'h01};
            S_CFG:   cmd = '{req: 1'b1, we: 1'b1, addr: REG_CFG,  wdata: 8'h01};
            S_ADDR:  cmd = '{req: 1'b1, we: 1'b1, addr: REG_ADDR, wdata: cur_addr};
            S_DATA:  cmd = '{req: 1'b1, we: 1'b1, addr: REG_DATA, wdata: cur_data};
            S_PROG:  cmd = '{req: 1'b1, we: 1'b1, addr: REG_CTRL, wdata: 8'h01};
            S_POLL:  cmd = '{req: 1'b1, we: 1'b0, addr: REG_CTRL, wdata: 8'h00};
            S_STAT:  cmd = '{req: 1'b1, we: 1'b0, addr: REG_STAT, wdata: 8'h00};
            default: cmd = '0;
        endcase
    end
endmodule

// File: rtl/otp_prog_seq.sv
`timescale 1ns/1ps
module otp_prog_seq #(
    parameter int MAX_ENTRIES = 4,
    parameter int MAX_TRIES   = 10,
    parameter int POLL_LIMIT  = 64,
    localparam int IDXW       = $clog2(MAX_ENTRIES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [IDXW-1:0]          n_entries,
    input  logic [8*MAX_ENTRIES-1:0] entry_addr,
    input  logic [8*MAX_ENTRIES-1:0] entry_data,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic [7:0]               bus_addr,
    output logic [7:0]               bus_wdata,
    input  logic                     bus_ack,
    input  logic [7:0]               bus_rdata,
    output logic                     busy,
    output logic                     done,
    output logic                     pass,
    output logic                     defective,
    output logic                     timeout_err,
    output logic                     addr_err,
    output logic [IDXW-1:0]          fail_idx
);
    import otp_seq_pkg::*;

    localparam int TRYW  = $clog2(MAX_TRIES + 1);
    localparam int POLLW = $clog2(POLL_LIMIT + 1);

    seq_state_t  state_q;
    logic [IDXW-1:0]  idx_q;
    logic [TRYW-1:0]  tries_q;
    logic [POLLW-1:0] poll_q;
    seq_result_t res_q;
    logic [IDXW-1:0]  fail_q;

    logic [7:0] cur_addr, cur_data;
    logic       past_end, addr_ok, is_zero;
    bus_cmd_t   cmd;
    logic       bit0;
    logic       unused_rdata_hi;

    assign bit0            = bus_rdata[0];
    assign unused_rdata_hi = ^bus_rdata[7:1];

    otp_entry_sel #(.MAX_ENTRIES(MAX_ENTRIES), .IDXW(IDXW)) u_sel (
        .n_entries (n_entries),
        .idx       (idx_q),
        .entry_addr(entry_addr),
        .entry_data(entry_data),
        .cur_addr  (cur_addr),
        .cur_data  (cur_data),
        .past_end  (past_end),
        .addr_ok   (addr_ok),
        .is_zero   (is_zero)
    );

    otp_bus_map u_map (
        .state   (state_q),
        .cur_addr(cur_addr),
        .cur_data(cur_data),
        .cmd     (cmd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            tries_q <= '0;
            poll_q  <= '0;
            res_q   <= '0;
            fail_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_CLKEN;
                    idx_q   <= '0;
                    res_q   <= '0;
                    fail_q  <= '0;
                end
                S_CLKEN: if (bus_ack) state_q <= S_PICK;
                S_PICK: begin
                    tries_q <= TRYW'(1);
                    if (past_end) begin
                        state_q    <= S_IDLE;
                        res_q.done <= 1'b1;
                        res_q.pass <= 1'b1;
                    end else if (!addr_ok) begin
                        state_q        <= S_IDLE;
                        res_q.done     <= 1'b1;
                        res_q.addr_err <= 1'b1;
                        fail_q         <= idx_q;
                    end else if (is_zero) begin
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        state_q <= S_CFG;
                    end
                end
                S_CFG:  if (bus_ack) state_q <= S_ADDR;
                S_ADDR: if (bus_ack) state_q <= S_DATA;
                S_DATA: if (bus_ack) state_q <= S_PROG;
                S_PROG: if (bus_ack) begin
                    poll_q  <= '0;
                    state_q <= S_POLL;
                end
                S_POLL: if (bus_ack) begin
                    if (!bit0) begin
                        state_q <= S_STAT;
                    end else if (poll_q == POLLW'(POLL_LIMIT - 1)) begin
                        state_q           <= S_IDLE;
                        res_q.done        <= 1'b1;
                        res_q.timeout_err <= 1'b1;
                        fail_q            <= idx_q;
                    end else begin
                        poll_q <= poll_q + 1'b1;
                    end
                end
                S_STAT: if (bus_ack) begin
                    if (bit0) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_PICK;
                    end else if (tries_q == TRYW'(MAX_TRIES)) begin
                        state_q         <= S_IDLE;
                        res_q.done      <= 1'b1;
                        res_q.defective <= 1'b1;
                        fail_q          <= idx_q;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                        state_q <= S_DATA;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign bus_req     = cmd.req;
    assign bus_we      = cmd.we;
    assign bus_addr    = cmd.addr;
    assign bus_wdata   = cmd.wdata;
    assign busy        = (state_q != S_IDLE);
    assign done        = res_q.done;
    assign pass        = res_q.pass;
    assign defective   = res_q.defective;
    assign timeout_err = res_q.timeout_err;
    assign addr_err    = res_q.addr_err;
    assign fail_idx    = fail_q;
endmodule

// File: rtl/otp_prog_seq_chk.sv
`timescale 1ns/1ps
module otp_prog_seq_chk #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            bus_req,
    input logic            bus_we,
    input logic [7:0]      bus_addr,
    input logic [7:0]      bus_wdata,
    input logic            bus_ack,
    input logic            busy,
    input logic            done,
    input logic            pass,
    input logic            defective,
    input logic            timeout_err,
    input logic            addr_err,
    input logic [IDXW-1:0] fail_idx
);
    import otp_seq_pkg::*;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req); // R11

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones({pass, defective, timeout_err, addr_err}) == 1); // R9

    AST_NO_ZERO_BURN: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && (bus_addr == REG_DATA) |-> bus_wdata != 8'h00); // R6

    AST_LOC_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && (bus_addr == REG_ADDR) |-> in_otp_range(bus_wdata)); // R7

    AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable({done, pass, defective, timeout_err, addr_err, fail_idx})); // R12

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done); // R12
endmodule

bind otp_prog_seq otp_prog_seq_chk #(.IDXW(IDXW)) u_chk (
    .clk(clk), .rst(rst), .start(start),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .busy(busy), .done(done), .pass(pass), .defective(defective),
    .timeout_err(timeout_err), .addr_err(addr_err), .fail_idx(fail_idx)
);

// File: tb/sim_otp_prog_seq.sv
`timescale 1ns/1ps
module sim_otp_prog_seq;
    localparam int NE   = 4;
    localparam int IDXW = 3;
    localparam int PLIM = 64;
    localparam int LOGN = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [IDXW-1:0] n_entries = '0;
    logic [8*NE-1:0] entry_addr = '0, entry_data = '0;
    logic bus_req, bus_we, bus_ack;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic busy, done, pass, defective, timeout_err, addr_err;
    logic [IDXW-1:0] fail_idx;

    always #2.5 clk = ~clk;

    otp_prog_seq #(.MAX_ENTRIES(NE), .MAX_TRIES(10), .POLL_LIMIT(PLIM)) u0 (
        .clk(clk), .rst(rst), .start(start), .n_entries(n_entries),
        .entry_addr(entry_addr), .entry_data(entry_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .pass(pass), .defective(defective),
        .timeout_err(timeout_err), .addr_err(addr_err), .fail_idx(fail_idx)
    );

    int total = 0, bad = 0;
    int lat = 0, poll_cfg = 0, poll_left = 0, fail_left = 0, hold_err = 0;
    int log_n = 0, exp_n = 0;
    logic [7:0] log_a [LOGN];
    logic       log_w [LOGN];
    logic [7:0] log_d [LOGN];
    logic [7:0] exp_a [LOGN];
    logic       exp_w [LOGN];
    logic [7:0] exp_d [LOGN];

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bus responder: drives on the falling edge
    initial begin
        int wait_cnt = 0;
        logic pr_req = 1'b0, pr_ack = 1'b0, pr_we = 1'b0;
        logic [7:0] pr_a = 8'h00, pr_d = 8'h00;
        bus_ack = 1'b0;
        bus_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (!rst && pr_req && !pr_ack &&
                (!bus_req || bus_we != pr_we || bus_addr != pr_a || bus_wdata != pr_d))
                hold_err++;
            if (rst || bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    bus_ack = 1'b1;
                    bus_rdata = 8'h00;
                    if (bus_we) begin
                        if (bus_addr == 8'h54) poll_left = poll_cfg;
                    end else if (bus_addr == 8'h54) begin
                        bus_rdata = (poll_left > 0) ? 8'h01 : 8'h00;
                        if (poll_left > 0) poll_left--;
                    end else if (bus_addr == 8'h58) begin
                        bus_rdata = (fail_left > 0) ? 8'h00 : 8'h01;
                        if (fail_left > 0) fail_left--;
                    end
                    if (log_n < LOGN) begin
                        log_a[log_n] = bus_addr;
                        log_w[log_n] = bus_we;
                        log_d[log_n] = bus_we ? bus_wdata : 8'h00;
                        log_n++;
                    end
                end else begin
                    wait_cnt++;
                end
            end
            pr_req = bus_req; pr_ack = bus_ack; pr_we = bus_we;
            pr_a = bus_addr; pr_d = bus_wdata;
        end
    end

    task automatic ex(input logic [7:0] a, input logic w, input logic [7:0] d);
        exp_a[exp_n] = a; exp_w[exp_n] = w; exp_d[exp_n] = d; exp_n++;
    endtask

    task automatic ex_try(input logic [7:0] d, input int polls);
        ex(8'h53, 1'b1, d);
        ex(8'h54, 1'b1, 8'h01);
        for (int i = 0; i < polls; i++) ex(8'h54, 1'b0, 8'h00);
    endtask

    task automatic ex_head(input logic [7:0] a);
        ex(8'h51, 1'b1, 8'h01);
        ex(8'h52, 1'b1, a);
    endtask

    task automatic cmp_log(input string tag);
        int mis = 0;
        chk(log_n == exp_n, {tag, " log length"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_a[i] != exp_a[i] || log_w[i] != exp_w[i] || log_d[i] != exp_d[i]) mis++;
        chk(mis == 0, {tag, " log content mismatches"}, mis, 0);
    endtask

    task automatic run_op(input int n, input logic [8*NE-1:0] a, input logic [8*NE-1:0] d,
                          input bit extra_start);
        int cyc = 0;
        @(negedge clk);
        log_n = 0;
        n_entries = IDXW'(n);
        entry_addr = a;
        entry_data = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1 / R12: busy rises, result cleared one cycle after start
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        chk(done == 1'b0, "R12 done cleared by start", done, 0);
        if (extra_start) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "run finished", done, 1);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R11 busy after reset", busy, 0);
        chk(bus_req == 1'b0, "R11 no request after reset", bus_req, 0);
        chk(done == 1'b0, "R12 done after reset", done, 0);
    endtask

    task automatic t_single;
        lat = 1; poll_cfg = 2; fail_left = 0;
        exp_n = 0;
        ex(8'h42, 1'b1, 8'h01);
        ex_head(8'hE0); ex_try(8'h5A, 3); ex(8'h58, 1'b0, 8'h00);
        run_op(1, 32'h0000_00E0, 32'h0000_005A, 1'b1);
        cmp_log("R1 R2 R3 R11 single entry");
        chk(pass == 1'b1, "R9 pass", pass, 1);
        chk(defective == 1'b0, "R9 no defect", defective, 0);
        repeat (12) @(negedge clk);
        chk(done && pass, "R12 result held", {done, pass}, 3);
        chk(bus_req == 1'b0, "R11 idle quiet", bus_req, 0);
    endtask

    task automatic t_retry_skip;
        lat = 0; poll_cfg = 0; fail_left = 1;
        exp_n = 0;
        ex(8'h42, 1'b1, 8'h01);
        ex_head(8'hDF); ex_try(8'h11, 1); ex(8'h58, 1'b0, 8'h00);
        ex_try(8'h11, 1); ex(8'h58, 1'b0, 8'h00);
        ex_head(8'hE8); ex_try(8'h22, 1); ex(8'h58, 1'b0, 8'h00);
        run_op(3, 32'h00E8_E3DF, 32'h0022_0011, 1'b0);
        cmp_log("R4 R6 retry and skip");
        chk(pass == 1'b1, "R9 pass after retry", pass, 1);
    endtask

    task automatic t_defective;
        lat = 0; poll_cfg = 0; fail_left = 100;
        exp_n = 0;
        ex(8'h42, 1'b1, 8'h01);
        ex_head(8'hE1);
        for (int i = 0; i < 10; i++) begin
            ex_try(8'h33, 1);
            ex(8'h58, 1'b0, 8'h00);
        end
        run_op(2, 32'h0000_E1E0, 32'h0000_3300, 1'b0);
        cmp_log("R5 ten attempts");
        chk(defective == 1'b1, "R5 defective", defective, 1);
        chk(pass == 1'b0, "R5 no pass", pass, 0);
        chk(fail_idx == 3'd1, "R5 fail_idx", fail_idx, 1);
        fail_left = 0;
    endtask

    task automatic t_addr_err;
        lat = 0; poll_cfg = 0; fail_left = 0;
        exp_n = 0;
        ex(8'h42, 1'b1, 8'h01);
        ex_head(8'hE2); ex_try(8'h44, 1); ex(8'h58, 1'b0, 8'h00);
        run_op(2, 32'h0000_E9E2, 32'h0000_5544, 1'b0);
        cmp_log("R7 high location");
        chk(addr_err == 1'b1, "R7 addr_err", addr_err, 1);
        chk(fail_idx == 3'd1, "R7 fail_idx", fail_idx, 1);
        chk(pass == 1'b0, "R7 no pass", pass, 0);
        exp_n = 0;
        ex(8'h42, 1'b1, 8'h01);
        run_op(1, 32'h0000_00DE, 32'h0000_0077, 1'b0);
        cmp_log("R7 low location");
        chk(addr_err == 1'b1 && fail_idx == 3'd0, "R7 first entry bad", addr_err, 1);
    endtask

    task automatic t_timeout;
        lat = 0; poll_cfg = 1000; fail_left = 0;
        exp_n = 0;
        ex(8'h42, 1'b1, 8'h01);
        ex_head(8'hE4); ex_try(8'h66, PLIM);
        run_op(1, 32'h0000_00E4, 32'h0000_0066, 1'b0);
        cmp_log("R8 poll reads");
        chk(timeout_err == 1'b1, "R8 timeout", timeout_err, 1);
        chk(defective == 1'b0, "R8 not defective", defective, 0);
        chk(pass == 1'b0, "R8 no pass", pass, 0);
        poll_cfg = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_retry_skip();
        t_defective();
        t_addr_err();
        t_timeout();
        chk(hold_err == 0, "R10 request held until ack", hold_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule